// File: doc/BRIEF.md
# Control Endpoint IN Data-Stage Responder

This block is the device-side responder for the IN half of a USB control transfer on endpoint 0 while the transfer is in its data stage. Firmware loads one packet of up to eight bytes into a small transmit buffer through a byte-wide write port. It then arms the packet with a trigger bit. A token-level interface decodes IN, OUT and ACK from the host. The block answers each IN token with either a NACK or the armed packet's bytes.

When the host acknowledges a packet, the buffer is released and a sticky completion flag is raised. If firmware has enabled it, an interrupt is raised as well. Firmware then clears the flag and loads the next packet. If the host sends an OUT token, the data stage is over. A setup-stage start pulse returns the endpoint to its initial condition. Serial encoding, CRC, PID handling and setup decoding sit outside this block.

Top module: `usb_ep0_in_xmit`

## Requirements
- R1: After reset the following are all 0: `resp_valid`, `resp_data`, `resp_len`, `tx_valid`, `tx_byte`, `tx_last`, `done_flag`, `irq`, `ovf_flag`, `fill_level` and `status_stage`.
- R2: Firmware confirms that it has read the setup data with a `fw_rd_done` pulse. Until then, an IN token is answered with a NACK. This means `resp_valid`=1 and `resp_data`=0 in the cycle after the token.
- R3: An IN token that arrives while no packet is armed is answered with a NACK.
- R4: An IN token that arrives with a packet of N>0 bytes armed gives `resp_valid`=1, `resp_data`=1 and `resp_len`=N in the cycle after the token. In that same cycle, `tx_valid` rises and stays high for N consecutive cycles. The bytes appear on `tx_byte` in the order they were written, and `tx_last` marks the final byte. When `tx_valid` is 0, `tx_byte` is 0.
- R5: Arming with zero bytes loaded gives a zero-length packet: `resp_data`=1, `resp_len`=0, and `tx_valid` is never asserted.
- R6: A `host_ack` after a packet has been sent has three effects in the next cycle: `done_flag` is set, the buffer is emptied (`fill_level`=0) and the packet is disarmed, so later IN tokens get a NACK. A `host_ack` when nothing has been sent has no effect.
- R7: A `fw_flag_clr` pulse clears `done_flag`. `irq` is high exactly while `done_flag` and the interrupt-enable bit (written through `fw_ie_we`/`fw_ie_din`) are both 1.
- R8: An IN token that arrives without an ACK for the previous transmission resends the same armed bytes unchanged.
- R9: Data writes and arm pulses are ignored while a packet is armed; `fill_level` does not change.
- R10: The buffer holds 8 bytes. A write when it is already full is dropped and sets `ovf_flag`, which stays set until the next setup start.
- R11: An OUT token during the data stage sets `status_stage`. After that, IN tokens are answered with a NACK even if a packet is armed.
- R12: A `setup_start` pulse does all of the following:
  - flushes and disarms the buffer;
  - clears `done_flag` and `ovf_flag`;
  - clears `status_stage`;
  - makes the endpoint wait again for `fw_rd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_start | input | 1 | Pulse at the start of a new setup stage |
| fw_rd_done | input | 1 | Firmware pulse: setup data has been read |
| fw_wr_en | input | 1 | Firmware data-register write strobe |
| fw_wr_data | input | 8 | Byte to append to the transmit buffer |
| fw_pkt_arm | input | 1 | Firmware pulse: arm the loaded packet |
| fw_flag_clr | input | 1 | Firmware pulse: clear the completion flag |
| fw_ie_we | input | 1 | Write strobe for the interrupt-enable bit |
| fw_ie_din | input | 1 | New interrupt-enable value |
| tok_in | input | 1 | IN token received (pulse) |
| tok_out | input | 1 | OUT token received (pulse) |
| host_ack | input | 1 | Host ACK handshake received (pulse) |
| resp_valid | output | 1 | One-cycle response decision for an IN token |
| resp_data | output | 1 | 1 = send data packet, 0 = NACK |
| resp_len | output | 4 | Length of the packet being sent |
| tx_valid | output | 1 | Transmit byte valid |
| tx_byte | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| done_flag | output | 1 | Transmit-complete flag |
| irq | output | 1 | Interrupt request |
| ovf_flag | output | 1 | Sticky buffer-overflow indication |
| fill_level | output | 4 | Bytes currently loaded |
| status_stage | output | 1 | Endpoint has moved to the status stage |

## Verification
The hardest state to reach is a retransmission: the packet has been sent but not acknowledged, and another IN token arrives. The stimulus creates it by issuing a second IN token before any `host_ack`. It then checks that the identical byte stream is produced. The zero-length packet and the overflowing ninth write are also reached only by specific firmware sequences. These are an arm with an empty buffer, and nine writes before an arm. A behavioural model tracks all of these cycle by cycle.

// File: rtl/ep0in_pkg.sv
// Package: shared stage encoding for the control-IN responder.
// Assumes: nothing beyond IEEE 1800-2017.
package ep0in_pkg;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,   // waiting for firmware setup-read confirmation
        ST_DATA   = 2'd1,   // data stage, IN tokens may be served
        ST_STATUS = 2'd2    // OUT seen, data stage finished
    } ep0_stage_e;

endpackage

// File: rtl/ep0in_txbuf.sv
// Module: ep0in_txbuf
// One-packet transmit buffer. Bytes are appended at the fill level and read
// by index. A flush empties it. Writes while locked are dropped silently;
// writes when full are dropped and raise a sticky overflow bit.
// Assumes: flush has priority over writes; the read index is below DEPTH.
module ep0in_txbuf #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             clr_ovf,
    input  logic             load_ok,
    input  logic             wr_req,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] count,
    output logic [DW-1:0]    rd_data,
    output logic             ovf
);

    logic [DW-1:0]    mem [DEPTH];
    logic             accept;
    logic             full;

    assign full   = (count == CNT_W'(DEPTH));
    assign accept = wr_req && load_ok && !flush && !full;

    // Per-entry storage: each slot captures the byte written at its position.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (accept && (count == CNT_W'(g)))
                mem[g] <= wr_data;
        end
    end

    // Fill level: advance on an accepted write, return to zero on flush.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (flush)
            count <= '0;
        else if (accept)
            count <= count + 1'b1;
    end

    // Overflow bit: set by a write to a full, unlocked buffer; cleared only by clr_ovf.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (clr_ovf)
            ovf <= 1'b0;
        else if (wr_req && load_ok && !flush && full)
            ovf <= 1'b1;
    end

    assign rd_data = mem[rd_idx];

    p_fill_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_locked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_ok && !flush) |=> $stable(count));

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);

endmodule

// File: rtl/ep0in_ctrl.sv
// Module: ep0in_ctrl
// Stage sequencing, arming, IN-token decisions, byte streaming, and the
// completion flag with its interrupt. It reads the buffer fill level and
// steers the buffer's read index and flush.
// Assumes: token and firmware inputs are single-cycle pulses; tokens that
// arrive while a packet is still streaming are ignored.
module ep0in_ctrl
    import ep0in_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_start,
    input  logic             fw_rd_done,
    input  logic             fw_pkt_arm,
    input  logic             fw_flag_clr,
    input  logic             fw_ie_we,
    input  logic             fw_ie_din,
    input  logic             tok_in,
    input  logic             tok_out,
    input  logic             host_ack,
    input  logic [CNT_W-1:0] count,
    output logic             armed,
    output logic             buf_flush,
    output logic [IDX_W-1:0] rd_idx,
    output logic             resp_valid,
    output logic             resp_data,
    output logic [CNT_W-1:0] resp_len,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             done_flag,
    output logic             irq,
    output logic             status_stage
);

    ep0_stage_e stage_q;
    logic       sent_q;
    logic       sending_q;
    logic       ie_q;
    logic       in_take;
    logic       serve;
    logic       ack_take;
    logic       at_last;

    assign in_take  = tok_in && !sending_q;
    assign serve    = in_take && (stage_q == ST_DATA) && armed;
    assign ack_take = host_ack && sent_q && !sending_q;
    assign at_last  = ((CNT_W'(rd_idx) + 1'b1) == count);
    assign buf_flush = setup_start || ack_take;

    // Stage sequencing: wait for setup read, data stage, then status on OUT.
    always_ff @(posedge clk) begin
        if (!rst_n || setup_start)
            stage_q <= ST_WAIT;
        else if (stage_q == ST_WAIT && fw_rd_done)
            stage_q <= ST_DATA;
        else if (stage_q == ST_DATA && tok_out)
            stage_q <= ST_STATUS;
    end

    // Arming: set by firmware when idle, released on host acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || setup_start)
            armed <= 1'b0;
        else if (ack_take)
            armed <= 1'b0;
        else if (fw_pkt_arm && !armed)
            armed <= 1'b1;
    end

    // Sent marker: a served packet awaits its acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || setup_start)
            sent_q <= 1'b0;
        else if (ack_take)
            sent_q <= 1'b0;
        else if (serve)
            sent_q <= 1'b1;
    end

    // Response decision: one-cycle report per accepted IN token.
    always_ff @(posedge clk) begin
        if (!rst_n || setup_start) begin
            resp_valid <= 1'b0;
            resp_data  <= 1'b0;
            resp_len   <= '0;
        end else begin
            resp_valid <= in_take;
            resp_data  <= serve;
            resp_len   <= serve ? count : '0;
        end
    end

    // Byte streamer: walk the buffer from index zero to the final byte.
    always_ff @(posedge clk) begin
        if (!rst_n || setup_start) begin
            sending_q <= 1'b0;
            rd_idx    <= '0;
        end else if (sending_q) begin
            if (at_last)
                sending_q <= 1'b0;
            else
                rd_idx <= rd_idx + 1'b1;
        end else if (serve && count != '0) begin
            sending_q <= 1'b1;
            rd_idx    <= '0;
        end
    end

    // Completion flag: raised on accepted acknowledge, cleared by firmware.
    always_ff @(posedge clk) begin
        if (!rst_n || setup_start)
            done_flag <= 1'b0;
        else if (ack_take)
            done_flag <= 1'b1;
        else if (fw_flag_clr)
            done_flag <= 1'b0;
    end

    // Interrupt-enable register bit, written by firmware.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie_q <= 1'b0;
        else if (fw_ie_we)
            ie_q <= fw_ie_din;
    end

    assign tx_valid     = sending_q;
    assign tx_last      = sending_q && at_last;
    assign irq          = done_flag && ie_q;
    assign status_stage = (stage_q == ST_STATUS);

    p_data_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_data) |-> ($past(stage_q) == ST_DATA && $past(armed)));

    p_flag_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !setup_start) |=> done_flag);

    p_status_nack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_stage && tok_in && !sending_q && !setup_start) |=> (resp_valid && !resp_data));

    p_setup_rewind_r12: assert property (@(posedge clk) disable iff (!rst_n)
        setup_start |=> (!armed && !done_flag && stage_q == ST_WAIT && !tx_valid));

endmodule

// File: rtl/usb_ep0_in_xmit.sv
// Module: usb_ep0_in_xmit (top)
// Control endpoint IN data-stage responder: connects the transmit buffer
// with the controller and gates the outgoing byte.
// Assumes: all inputs are synchronous to clk; firmware strobes are pulses.
module usb_ep0_in_xmit #(
    parameter int PKT_BYTES = 8,
    parameter int DW        = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              setup_start,
    input  logic                              fw_rd_done,
    input  logic                              fw_wr_en,
    input  logic [DW-1:0]                     fw_wr_data,
    input  logic                              fw_pkt_arm,
    input  logic                              fw_flag_clr,
    input  logic                              fw_ie_we,
    input  logic                              fw_ie_din,
    input  logic                              tok_in,
    input  logic                              tok_out,
    input  logic                              host_ack,
    output logic                              resp_valid,
    output logic                              resp_data,
    output logic [$clog2(PKT_BYTES+1)-1:0]    resp_len,
    output logic                              tx_valid,
    output logic [DW-1:0]                     tx_byte,
    output logic                              tx_last,
    output logic                              done_flag,
    output logic                              irq,
    output logic                              ovf_flag,
    output logic [$clog2(PKT_BYTES+1)-1:0]    fill_level,
    output logic                              status_stage
);

    localparam int CNT_W = $clog2(PKT_BYTES + 1);
    localparam int IDX_W = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1;

    logic             armed;
    logic             buf_flush;
    logic [IDX_W-1:0] rd_idx;
    logic [DW-1:0]    rd_data;
    logic [CNT_W-1:0] count;

    ep0in_txbuf #(.DEPTH(PKT_BYTES), .DW(DW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (buf_flush),
        .clr_ovf (setup_start),
        .load_ok (!armed),
        .wr_req  (fw_wr_en),
        .wr_data (fw_wr_data),
        .rd_idx  (rd_idx),
        .count   (count),
        .rd_data (rd_data),
        .ovf     (ovf_flag)
    );

    ep0in_ctrl #(.DEPTH(PKT_BYTES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .setup_start  (setup_start),
        .fw_rd_done   (fw_rd_done),
        .fw_pkt_arm   (fw_pkt_arm),
        .fw_flag_clr  (fw_flag_clr),
        .fw_ie_we     (fw_ie_we),
        .fw_ie_din    (fw_ie_din),
        .tok_in       (tok_in),
        .tok_out      (tok_out),
        .host_ack     (host_ack),
        .count        (count),
        .armed        (armed),
        .buf_flush    (buf_flush),
        .rd_idx       (rd_idx),
        .resp_valid   (resp_valid),
        .resp_data    (resp_data),
        .resp_len     (resp_len),
        .tx_valid     (tx_valid),
        .tx_last      (tx_last),
        .done_flag    (done_flag),
        .irq          (irq),
        .status_stage (status_stage)
    );

    assign tx_byte    = tx_valid ? rd_data : '0;
    assign fill_level = count;

    p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);

endmodule

// File: tb/tb_usb_ep0_in_xmit.sv
module tb_usb_ep0_in_xmit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       setup_start = 0, fw_rd_done = 0, fw_wr_en = 0, fw_pkt_arm = 0;
    logic       fw_flag_clr = 0, fw_ie_we = 0, fw_ie_din = 0;
    logic       tok_in = 0, tok_out = 0, host_ack = 0;
    logic [7:0] fw_wr_data = '0;
    logic       resp_valid, resp_data, tx_valid, tx_last, done_flag, irq, ovf_flag, status_stage;
    logic [3:0] resp_len, fill_level;
    logic [7:0] tx_byte;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    cmp_on = 0;

    always #4 clk = ~clk;

    usb_ep0_in_xmit dut (
        .clk(clk), .rst_n(rst_n), .setup_start(setup_start), .fw_rd_done(fw_rd_done),
        .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data), .fw_pkt_arm(fw_pkt_arm),
        .fw_flag_clr(fw_flag_clr), .fw_ie_we(fw_ie_we), .fw_ie_din(fw_ie_din),
        .tok_in(tok_in), .tok_out(tok_out), .host_ack(host_ack),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_len(resp_len),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
        .done_flag(done_flag), .irq(irq), .ovf_flag(ovf_flag),
        .fill_level(fill_level), .status_stage(status_stage)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_q[$];
    int  m_stage, m_idx, m_rlen;
    bit  m_armed, m_sent, m_sending, m_flag, m_ie, m_ovf, m_rv, m_rd;
    bit  o_send, o_sent, o_armed;
    int  o_stage;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete(); m_stage = 0; m_idx = 0; m_rlen = 0;
            m_armed = 0; m_sent = 0; m_sending = 0; m_flag = 0; m_ie = 0;
            m_ovf = 0; m_rv = 0; m_rd = 0;
        end else if (setup_start) begin
            m_q.delete(); m_stage = 0; m_idx = 0; m_rlen = 0;
            m_armed = 0; m_sent = 0; m_sending = 0; m_flag = 0;
            m_ovf = 0; m_rv = 0; m_rd = 0;
            if (fw_ie_we) m_ie = fw_ie_din;
        end else begin
            o_send = m_sending; o_sent = m_sent; o_armed = m_armed; o_stage = m_stage;
            m_rv = 0; m_rd = 0; m_rlen = 0;
            if (o_send) begin
                if (m_idx == m_q.size() - 1) m_sending = 0;
                else m_idx++;
            end
            if (tok_in && !o_send) begin
                m_rv = 1;
                if (o_stage == 1 && o_armed) begin
                    m_rd = 1; m_rlen = m_q.size(); m_sent = 1;
                    if (m_q.size() > 0) begin m_sending = 1; m_idx = 0; end
                end
            end
            if (host_ack && o_sent && !o_send) begin
                m_flag = 1; m_armed = 0; m_sent = 0; m_q.delete();
            end else begin
                if (fw_flag_clr) m_flag = 0;
                if (fw_pkt_arm && !o_armed) m_armed = 1;
                if (fw_wr_en && !o_armed) begin
                    if (m_q.size() < 8) m_q.push_back(fw_wr_data);
                    else m_ovf = 1;
                end
            end
            if (fw_ie_we) m_ie = fw_ie_din;
            if (o_stage == 0 && fw_rd_done) m_stage = 1;
            else if (o_stage == 1 && tok_out) m_stage = 2;
        end
    end

    task automatic cmp1(string nm, int got, int exp);
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got=%0d exp=%0d t=%0t", cur_req, nm, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            cmp1("resp_valid", resp_valid, m_rv);
            cmp1("resp_data", resp_data, m_rd);
            cmp1("resp_len", resp_len, m_rlen);
            cmp1("tx_valid", tx_valid, m_sending);
            cmp1("tx_byte", tx_byte, m_sending ? int'(m_q[m_idx]) : 0);
            cmp1("tx_last", tx_last, (m_sending && m_idx == m_q.size() - 1) ? 1 : 0);
            cmp1("done_flag", done_flag, m_flag);
            cmp1("irq", irq, (m_flag && m_ie) ? 1 : 0);
            cmp1("ovf_flag", ovf_flag, m_ovf);
            cmp1("fill_level", fill_level, m_q.size());
            cmp1("status_stage", status_stage, (m_stage == 2) ? 1 : 0);
        end
    end

    // ---------------- directed checks and stimulus ----------------
    task automatic chk(string req, string nm, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got=%0d exp=%0d t=%0t", req, nm, got, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic [7:0] b);
        fw_wr_en = 1; fw_wr_data = b; step(); fw_wr_en = 0;
    endtask

    task automatic p_in();    tok_in = 1;      step(); tok_in = 0;      endtask
    task automatic p_out();   tok_out = 1;     step(); tok_out = 0;     endtask
    task automatic p_ack();   host_ack = 1;    step(); host_ack = 0;    endtask
    task automatic p_arm();   fw_pkt_arm = 1;  step(); fw_pkt_arm = 0;  endtask
    task automatic p_rdd();   fw_rd_done = 1;  step(); fw_rd_done = 0;  endtask
    task automatic p_clr();   fw_flag_clr = 1; step(); fw_flag_clr = 0; endtask
    task automatic p_setup(); setup_start = 1; step(); setup_start = 0; endtask
    task automatic set_ie(logic v);
        fw_ie_we = 1; fw_ie_din = v; step(); fw_ie_we = 0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1;
        cmp_on = 1;
        step();
        // R1: reset state
        cur_req = "R1";
        chk("R1", "resp_valid", resp_valid, 0);
        chk("R1", "done_flag", done_flag, 0);
        chk("R1", "fill_level", fill_level, 0);
        chk("R1", "status_stage", status_stage, 0);

        // R2: IN before setup-read confirmation is refused
        cur_req = "R2";
        p_in();
        chk("R2", "resp_valid", resp_valid, 1);
        chk("R2", "resp_data", resp_data, 0);

        // R3: nothing armed
        cur_req = "R3";
        p_rdd();
        p_in();
        chk("R3", "resp_data", resp_data, 0);

        // R4: three-byte packet streamed in order
        cur_req = "R4";
        set_ie(1);
        wr(8'h11); wr(8'h22); wr(8'h33);
        p_arm();
        p_in();
        chk("R4", "resp_data", resp_data, 1);
        chk("R4", "resp_len", resp_len, 3);
        chk("R4", "tx_byte0", tx_byte, 8'h11);
        step();
        chk("R4", "tx_byte1", tx_byte, 8'h22);
        step();
        chk("R4", "tx_last", tx_last, 1);
        chk("R4", "tx_byte2", tx_byte, 8'h33);
        idle(2);

        // R8: another IN without ACK resends the same packet
        cur_req = "R8";
        p_in();
        chk("R8", "tx_byte0", tx_byte, 8'h11);
        idle(3);

        // R9: writes and arms while armed are dropped
        cur_req = "R9";
        wr(8'h99);
        p_arm();
        chk("R9", "fill_level", fill_level, 3);

        // R6: acknowledge releases the buffer and sets the flag
        cur_req = "R6";
        p_ack();
        chk("R6", "done_flag", done_flag, 1);
        chk("R6", "fill_level", fill_level, 0);
        p_in();
        chk("R6", "resp_data", resp_data, 0);

        // R7: interrupt gating and flag clear
        cur_req = "R7";
        chk("R7", "irq_on", irq, 1);
        set_ie(0);
        chk("R7", "irq_masked", irq, 0);
        set_ie(1);
        p_clr();
        chk("R7", "done_flag", done_flag, 0);
        chk("R7", "irq_off", irq, 0);

        // R10: nine writes, the last overflows
        cur_req = "R10";
        for (int i = 0; i < 9; i++) wr(8'h40 + 8'(i));
        chk("R10", "ovf_flag", ovf_flag, 1);
        chk("R10", "fill_level", fill_level, 8);
        p_arm();
        p_in();
        chk("R10", "resp_len", resp_len, 8);
        idle(10);
        p_ack();
        p_clr();
        chk("R10", "ovf_sticky", ovf_flag, 1);

        // R5: zero-length packet
        cur_req = "R5";
        p_arm();
        p_in();
        chk("R5", "resp_data", resp_data, 1);
        chk("R5", "resp_len", resp_len, 0);
        chk("R5", "tx_valid", tx_valid, 0);
        step();
        p_ack();
        chk("R5", "done_flag", done_flag, 1);
        p_clr();

        // R11: OUT ends the data stage
        cur_req = "R11";
        wr(8'hA1); wr(8'hA2);
        p_arm();
        p_out();
        chk("R11", "status_stage", status_stage, 1);
        p_in();
        chk("R11", "resp_valid", resp_valid, 1);
        chk("R11", "resp_data", resp_data, 0);

        // R12: setup start rewinds everything
        cur_req = "R12";
        p_setup();
        chk("R12", "fill_level", fill_level, 0);
        chk("R12", "status_stage", status_stage, 0);
        chk("R12", "ovf_flag", ovf_flag, 0);
        p_in();
        chk("R12", "resp_data", resp_data, 0);
        p_rdd();
        cur_req = "R6";
        p_ack();
        chk("R6", "ack_ignored", done_flag, 0);
        cur_req = "R12";
        wr(8'h5A);
        p_arm();
        p_in();
        chk("R12", "tx_byte", tx_byte, 8'h5A);
        chk("R12", "tx_last", tx_last, 1);
        step();
        p_ack();
        chk("R12", "done_flag", done_flag, 1);
        idle(2);

        finish_run();
    end

endmodule